// File: doc/BRIEF.md
# Flash Command Register Controller

This block is a clock-synchronous model of the command front end of a byte-wide parallel flash that erases as a whole chip and programs one byte at a time. It samples the bus strobes (active-low chip enable, output enable and write enable), a 16-bit address and an 8-bit write-data bus on the system clock. Each completed bus write is decoded as a command. The command selects how later reads are served and which operation the cell array performs. The block does not hold the cells. It drives a small array port: a read address, a margin-verify strobe, a one-cycle program strobe with its address and byte, and a one-cycle erase-all strobe. It takes the array's read byte back and presents it on the data output, together with a drive-enable that stands in for a tri-state data bus.

Writes are accepted only while the high-voltage-present input is asserted. While it is low, the command state is held at read mode, so the device acts as a read-only memory. Two internal stop timers, counted in clock cycles, bound how long a program or erase may run when no verify command ends it. Once a timer expires, the block waits for a verify or reset command.

Top module: `flashcmd_ctrl`

## Requirements
- R1: After reset the mode is read, `prog_busy`, `erase_busy` and `dout_en` are 0. In read mode a read returns the array byte at the bus address. Command code 00h and any undefined code select read mode.
- R2: While `hv_ok` is 0, every bus write is ignored and the mode is forced to read. If `hv_ok` falls during an operation, the matching busy flag is 0 at the next clock.
- R3: `dout_en` is 1 exactly when `ce_n` and `oe_n` are both 0. Otherwise `dout` is 00h.
- R4: After command 90h, a read whose address bit 0 is 0 returns 20h, and a read whose address bit 0 is 1 returns 02h.
- R5: Command 20h followed by a second 20h pulses `arr_erase` and raises `erase_busy`. Command 20h followed by any other byte starts nothing and returns to read mode.
- R6: Command A0h ends a running erase and latches the write address. Later reads return the array byte at that latched address with `arr_margin` = 1, whatever the bus address.
- R7: After command 40h, the next write pulses `arr_prog` with the address taken at write-enable fall and the data taken at write-enable rise, and raises `prog_busy`.
- R8: Command C0h ends a running program. Later reads return the byte at the programmed address with `arr_margin` = 1.
- R9: A single FFh leaves a running operation untouched. A second consecutive FFh ends it and selects read mode. Every other accepted command write also ends a running operation.
- R10: `prog_busy` stays high for exactly `PROG_LIMIT` cycles and `erase_busy` for exactly `ERASE_LIMIT` cycles when no command ends them. The mode is then kept, waiting for a verify or reset command. The two busy flags are never high together.
- R11: A write's address is the value on `addr` in the cycle where `we_n` is first seen low with `ce_n` low. Address changes before `we_n` rises are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hv_ok | input | 1 | Programming supply present; enables writes |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Bus address |
| din | input | DW | Bus write data |
| dout | output | DW | Bus read data |
| dout_en | output | 1 | Data output drive enable |
| arr_addr | output | AW | Array read address |
| arr_rd | output | 1 | Array read strobe |
| arr_margin | output | 1 | Read under margin-verify conditions |
| arr_rdata | input | DW | Array read byte |
| arr_prog | output | 1 | One-cycle program strobe |
| arr_waddr | output | AW | Program address |
| arr_wdata | output | DW | Program byte |
| arr_erase | output | 1 | One-cycle erase-all strobe |
| prog_busy | output | 1 | Program operation running |
| erase_busy | output | 1 | Erase operation running |

## Verification
Reads are combinational from the bus and the current mode. The bench therefore samples `dout`, `dout_en` and `arr_margin` 2 ns after it drives a read, in the same cycle. A command takes effect at the clock edge that sees `we_n` high after a latched fall. Each write task returns at the falling edge after that clock edge, so the mode, the busy flags and the array strobes' effects are checked at that point. Busy durations are measured by counting falling edges from that point until the flag drops, and the count is compared with the bench's limit parameters. A drop of `hv_ok` is checked one falling edge later.

// File: rtl/flashcmd_pkg.sv
// Package: command codes, identification bytes and the mode encoding
// shared by the command decoder and the top level.
package flashcmd_pkg;
    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_SIG    = 8'h90;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_EVFY   = 8'hA0;
    localparam logic [7:0] CMD_PROG   = 8'h40;
    localparam logic [7:0] CMD_PVFY   = 8'hC0;
    localparam logic [7:0] CMD_RESET  = 8'hFF;
    localparam logic [7:0] ID_MAKER   = 8'h20;
    localparam logic [7:0] ID_DEVICE  = 8'h02;

    typedef enum logic [3:0] {
        M_READ, M_SIG, M_ERS_SET, M_ERS_RUN, M_ERS_VFY,
        M_PGM_SET, M_PGM_RUN, M_PGM_VFY, M_RST_SET
    } mode_t;
endpackage

// File: rtl/flashcmd_wrsync.sv
// Bus write detector. Opens a write when we_n is seen low with ce_n low
// and latches the address there; closes it on the first cycle we_n is
// high again and flags that cycle. Assumes the strobes are synchronous
// to clk or were synchronised before this block.
module flashcmd_wrsync #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic          wr_rise,
    output logic [AW-1:0] wr_addr
);
    logic we_q;
    logic open_q;
    logic fall;

    assign fall    = we_q && !we_n && !ce_n && !open_q;
    assign wr_rise = open_q && we_n;

    // Track write enable, open and close the write, capture the address at the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b1;
            open_q  <= 1'b0;
            wr_addr <= '0;
        end else begin
            we_q <= we_n;
            if (fall) begin
                open_q  <= 1'b1;
                wr_addr <= addr;
            end else if (wr_rise) begin
                open_q <= 1'b0;
            end
        end
    end

    assert_rise_after_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |-> !$past(we_n));
endmodule

// File: rtl/flashcmd_timer.sv
// Operation stop timer. Start loads the limit and raises busy; busy
// falls when the count runs out or halt is seen. Start wins over halt.
module flashcmd_timer #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic halt,
    output logic busy
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    // Count down the remaining cycles of a running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(LIMIT - 1);
        end else if (halt) begin
            busy <= 1'b0;
        end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/flashcmd_fsm.sv
// Command decoder. On each accepted write it moves the mode register,
// latches the verify/program target address, issues start strobes for
// program and erase, and a halt that ends a running operation. Assumes
// wr_rise is a single-cycle pulse per bus write.
module flashcmd_fsm
    import flashcmd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hv_ok,
    input  logic          wr_rise,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] din,
    output mode_t         mode_q,
    output logic [AW-1:0] tgt_q,
    output logic          ers_go,
    output logic          pgm_go,
    output logic          halt
);
    mode_t         mode_d;
    mode_t         fresh;
    logic [AW-1:0] tgt_d;

    // Map a first-cycle command byte to the mode it selects.
    function automatic mode_t decode(input logic [DW-1:0] code);
        case (code)
            CMD_SIG:   return M_SIG;
            CMD_ERASE: return M_ERS_SET;
            CMD_EVFY:  return M_ERS_VFY;
            CMD_PROG:  return M_PGM_SET;
            CMD_PVFY:  return M_PGM_VFY;
            CMD_RESET: return M_RST_SET;
            default:   return M_READ;
        endcase
    endfunction

    assign fresh = decode(din);

    // Next-state, target address and strobe decode for one accepted write.
    always_comb begin
        mode_d = mode_q;
        tgt_d  = tgt_q;
        ers_go = 1'b0;
        pgm_go = 1'b0;
        halt   = !hv_ok;
        if (!hv_ok) begin
            mode_d = M_READ;
        end else if (wr_rise) begin
            case (mode_q)
                M_ERS_SET: begin
                    if (din == CMD_ERASE) begin
                        mode_d = M_ERS_RUN;
                        ers_go = 1'b1;
                    end else begin
                        mode_d = M_READ;
                    end
                end
                M_PGM_SET: begin
                    mode_d = M_PGM_RUN;
                    pgm_go = 1'b1;
                    tgt_d  = wr_addr;
                end
                M_RST_SET: begin
                    halt   = 1'b1;
                    mode_d = (din == CMD_RESET) ? M_READ : fresh;
                    if (fresh == M_ERS_VFY) tgt_d = wr_addr;
                end
                default: begin
                    mode_d = fresh;
                    halt   = (fresh != M_RST_SET);
                    if (fresh == M_ERS_VFY) tgt_d = wr_addr;
                end
            endcase
        end
    end

    // Mode and target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_READ;
            tgt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            tgt_q  <= tgt_d;
        end
    end

    assert_erase_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ers_go |-> (mode_q == M_ERS_SET));
    assert_hv_low_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_ok |=> (mode_q == M_READ));
endmodule

// File: rtl/flashcmd_ctrl.sv
// Top level of the flash command front end. Ties the write detector,
// command decoder and two stop timers together and muxes the read path.
// Reads are combinational from the bus and mode; the array is external.
module flashcmd_ctrl
    import flashcmd_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int PROG_LIMIT  = 500,
    parameter int ERASE_LIMIT = 500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hv_ok,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic [AW-1:0] arr_addr,
    output logic          arr_rd,
    output logic          arr_margin,
    input  logic [DW-1:0] arr_rdata,
    output logic          arr_prog,
    output logic [AW-1:0] arr_waddr,
    output logic [DW-1:0] arr_wdata,
    output logic          arr_erase,
    output logic          prog_busy,
    output logic          erase_busy
);
    logic          wr_rise;
    logic [AW-1:0] wr_addr;
    mode_t         mode_q;
    logic [AW-1:0] tgt_q;
    logic          ers_go;
    logic          pgm_go;
    logic          halt;
    logic          in_vfy;
    logic [DW-1:0] rd_val;

    flashcmd_wrsync #(.AW(AW)) wrsync_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .wr_rise(wr_rise), .wr_addr(wr_addr)
    );

    flashcmd_fsm #(.AW(AW), .DW(DW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .wr_rise(wr_rise),
        .wr_addr(wr_addr), .din(din), .mode_q(mode_q), .tgt_q(tgt_q),
        .ers_go(ers_go), .pgm_go(pgm_go), .halt(halt)
    );

    flashcmd_timer #(.LIMIT(PROG_LIMIT)) pgm_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(pgm_go), .halt(halt), .busy(prog_busy)
    );

    flashcmd_timer #(.LIMIT(ERASE_LIMIT)) ers_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(ers_go), .halt(halt), .busy(erase_busy)
    );

    // Array program and erase strobes, valid in the write-completion cycle.
    assign arr_prog  = pgm_go;
    assign arr_waddr = wr_addr;
    assign arr_wdata = din;
    assign arr_erase = ers_go;

    // Read path: verify modes read the latched target under margin.
    assign in_vfy     = (mode_q == M_ERS_VFY) || (mode_q == M_PGM_VFY);
    assign dout_en    = !ce_n && !oe_n;
    assign arr_addr   = in_vfy ? tgt_q : addr;
    assign arr_margin = in_vfy;
    assign arr_rd     = dout_en && (mode_q != M_SIG);
    assign rd_val     = (mode_q == M_SIG) ? (addr[0] ? ID_DEVICE : ID_MAKER) : arr_rdata;
    assign dout       = dout_en ? rd_val : '0;

    assert_one_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_busy && erase_busy));
    assert_hv_drop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_ok |=> (!prog_busy && !erase_busy));
endmodule

// File: tb/flashcmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flashcmd_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int PL = 40;
    localparam int EL = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hv_ok = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic [AW-1:0] arr_addr;
    logic          arr_rd;
    logic          arr_margin;
    logic [DW-1:0] arr_rdata;
    logic          arr_prog;
    logic [AW-1:0] arr_waddr;
    logic [DW-1:0] arr_wdata;
    logic          arr_erase;
    logic          prog_busy;
    logic          erase_busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] cells [256];
    logic [7:0] model [256];
    logic [7:0] rd_d;
    logic       rd_en;
    logic       rd_m;

    always #10 clk = ~clk;

    flashcmd_ctrl #(.AW(AW), .DW(DW), .PROG_LIMIT(PL), .ERASE_LIMIT(EL)) dut_i (
        .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .arr_addr(arr_addr), .arr_rd(arr_rd), .arr_margin(arr_margin),
        .arr_rdata(arr_rdata), .arr_prog(arr_prog), .arr_waddr(arr_waddr),
        .arr_wdata(arr_wdata), .arr_erase(arr_erase),
        .prog_busy(prog_busy), .erase_busy(erase_busy)
    );

    // Behavioural cell array.
    assign arr_rdata = cells[arr_addr[7:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) cells[i] <= 8'(i) ^ 8'h5A;
        end else if (arr_erase) begin
            for (int i = 0; i < 256; i++) cells[i] <= 8'hFF;
        end else if (arr_prog) begin
            cells[arr_waddr[7:0]] <= arr_wdata;
        end
    end

    function automatic logic [7:0] sig_byte(input logic [15:0] a);
        return a[0] ? 8'h02 : 8'h20;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] fa, input logic [15:0] ra, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = fa; we_n = 1'b0;
        @(negedge clk); addr = ra; din = d; we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic cmd(input logic [7:0] d);
        bus_write(16'h0, 16'h0, d);
    endtask

    task automatic bus_read(input logic [15:0] a);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #2; rd_d = dout; rd_en = dout_en; rd_m = arr_margin;
        @(negedge clk); oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic model_erase();
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] ra;
        logic [7:0] rv;
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and read mode
        check("R1 prog_busy", prog_busy, 0);
        check("R1 erase_busy", erase_busy, 0);
        check("R1 dout_en", dout_en, 0);
        bus_read(16'h0005); check("R1 read", rd_d, model[5]);

        // R3: output gating
        @(negedge clk); ce_n = 0; oe_n = 1; #2; check("R3 oe high", {dout_en, dout}, 0);
        ce_n = 1; oe_n = 0; #2; check("R3 ce high", {dout_en, dout}, 0);
        oe_n = 1;
        bus_read(16'h0007); check("R3 both low", rd_en, 1);

        // R4: signature bytes, directed then random addresses
        cmd(8'h90);
        bus_read(16'h0000); check("R4 maker", rd_d, 8'h20);
        bus_read(16'h0001); check("R4 device", rd_d, 8'h02);
        for (int k = 0; k < 6; k++) begin
            ra = 8'($urandom);
            bus_read({8'h0, ra}); check("R4 random", rd_d, sig_byte({8'h0, ra}));
        end

        // R7/R11: program with address moved between fall and rise
        cmd(8'h40);
        bus_write(16'h0012, 16'h0034, 8'h3C); model[8'h12] = 8'h3C;
        check("R7 prog_busy", prog_busy, 1);
        // R8: program verify stops it and reads latched address under margin
        cmd(8'hC0);
        check("R8 stop", prog_busy, 0);
        bus_read(16'h0099); check("R11 R8 verify data", rd_d, 8'h3C);
        check("R8 margin", rd_m, 1);
        cmd(8'h00);
        bus_read(16'h0034); check("R11 untouched", rd_d, model[8'h34]);

        // R7/R8: random program then verify
        for (int k = 0; k < 4; k++) begin
            ra = 8'($urandom); rv = 8'($urandom);
            cmd(8'h40); bus_write({8'h0, ra}, {8'h0, ra}, rv); model[ra] = rv;
            cmd(8'hC0); bus_read(16'h00F0); check("R8 random verify", rd_d, rv);
        end
        cmd(8'h33); // R1 undefined code selects read
        for (int k = 0; k < 8; k++) begin
            ra = 8'($urandom);
            bus_read({8'h0, ra}); check("R1 random read", rd_d, model[ra]);
        end

        // R10: program stop timer
        cmd(8'h40); bus_write(16'h0020, 16'h0020, 8'h77); model[8'h20] = 8'h77;
        n = 0;
        while (prog_busy && n < 100000) begin n++; @(negedge clk); end
        check("R10 program length", n, PL);
        bus_read(16'h0021); check("R10 mode kept read", rd_d, model[8'h21]);
        cmd(8'hC0); bus_read(16'h0000); check("R10 verify after stop", rd_d, 8'h77);

        // R5: erase setup aborted by other byte
        cmd(8'h20); cmd(8'h55);
        check("R5 abort busy", erase_busy, 0);
        bus_read(16'h0020); check("R5 abort no erase", rd_d, 8'h77);

        // R5/R9: erase then doubled reset
        cmd(8'h20); cmd(8'h20); model_erase();
        check("R5 erase busy", erase_busy, 1);
        cmd(8'hFF); check("R9 single reset keeps", erase_busy, 1);
        cmd(8'hFF); check("R9 double reset stops", erase_busy, 0);
        bus_read(16'h0012); check("R9 read mode", {rd_m, rd_d}, {1'b0, 8'hFF});

        // R6: erase verify stops erase, reads latched address under margin
        cmd(8'h40); bus_write(16'h0040, 16'h0040, 8'h11); model[8'h40] = 8'h11;
        cmd(8'hC0);
        bus_write(16'h0040, 16'h0003, 8'hA0);
        bus_read(16'h0003); check("R6 verify data", rd_d, 8'h11);
        check("R6 margin", rd_m, 1);
        cmd(8'h20); cmd(8'h20); model_erase();
        bus_write(16'h0050, 16'h0050, 8'hA0);
        check("R6 erase stopped", erase_busy, 0);
        bus_read(16'h0050); check("R6 erased byte", rd_d, 8'hFF);

        // R10: erase stop timer
        cmd(8'h20); cmd(8'h20);
        n = 0;
        while (erase_busy && n < 100000) begin n++; @(negedge clk); end
        check("R10 erase length", n, EL);

        // R2: writes ignored while supply low
        hv_ok = 1'b0;
        cmd(8'h90);
        bus_read(16'h0000); check("R2 no signature", rd_d, model[0]);
        cmd(8'h40); bus_write(16'h0005, 16'h0005, 8'h00);
        bus_read(16'h0005); check("R2 no program", rd_d, model[5]);
        check("R2 no busy", prog_busy, 0);
        hv_ok = 1'b1;
        cmd(8'h20); cmd(8'h20);
        hv_ok = 1'b0;
        @(negedge clk); check("R2 drop stops erase", erase_busy, 0);
        hv_ok = 1'b1;
        bus_read(16'h0001); check("R2 back in read", {rd_m, rd_d}, {1'b0, 8'hFF});

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule